// File: doc/BRIEF.md
# Configurable Branch Direction Predictor

This block predicts whether a conditional branch is taken. A lookup port takes a branch address and, in the same cycle and with no register on the path, returns one taken/not-taken bit. An update port takes the address of a branch that has resolved, together with its real outcome, and trains the predictor's tables on the next rising clock edge.

A two-bit mode input picks the policy at run time. Two policies are static: always not-taken and always taken. The third is a bimodal table of 2-bit saturating counters, indexed directly by address bits. The fourth is a two-level adaptive scheme. In that scheme a table of per-address history shift registers supplies a recent-outcome pattern, and the pattern, joined with a few address bits, selects a counter in a second table. Elaboration parameters set the bimodal table size, the history table size, the counter table size and the history width, each one independently of the others.

Top module: `branch_dir_predictor`

## Requirements
- R1: With mode_sel = 2'b00 the lookup output is 0 for every address.
- R2: With mode_sel = 2'b01 the lookup output is 1 for every address.
- R3: With mode_sel = 2'b10 the prediction is bit 1 of the bimodal counter at index lk_addr[WORD_OFS +: log2(BIM_ENTRIES)]. It is formed combinationally in the same cycle as the lookup.
- R4: An update moves the selected 2-bit counter up by one on taken and down by one on not-taken. The counter holds at 3 on a taken update and at 0 on a not-taken update.
- R5: Reset, active low and asynchronous, sets every counter in both counter tables to 2'b01 and clears every history register. After reset, modes 2'b10 and 2'b11 predict not-taken everywhere.
- R6: With mode_sel = 2'b11 the history register at index addr[WORD_OFS +: log2(L1_ENTRIES)] is used. An update shifts that register left by one and puts the outcome into bit 0.
- R7: In two-level mode the counter index is {history, addr[WORD_OFS +: log2(L2_ENTRIES) - HIST_W]}, with the history as the upper part. On update, the counter is chosen by the history as it stood before the shift.
- R8: An update changes only the tables of the mode that is currently selected. Updates in the static modes change no table at all.
- R9: A lookup in the same cycle as an update sees the table contents from before that update. The update becomes visible to lookups from the next cycle on.
- R10: Addresses that differ only in bits above the bimodal index share one bimodal counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | 00 static not-taken, 01 static taken, 10 bimodal, 11 two-level |
| lk_addr | input | ADDR_W | Address of the branch being predicted |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| upd_valid | input | 1 | An update is presented this cycle |
| upd_addr | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
A single bimodal address is first trained upward past saturation and then downward past zero. This shows the increment, the decrement and both saturation limits as separate changes in the predicted bit. An alias address, which differs only in bits above the index, then trains the shared entry, while a neighbouring index is left alone. Runs of taken updates given in the static modes, followed by a return to bimodal mode, show whether those updates leaked into the table. A two-level training run on one branch moves its history from all-zeros to all-ones. The way that branch's prediction then follows the history, and differs from the result a bimodal table would give, separates the history-based selection from the address-only selection.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef enum logic [1:0] {
    BP_STATIC_NT = 2'b00,
    BP_STATIC_T  = 2'b01,
    BP_BIMODAL   = 2'b10,
    BP_TWO_LEVEL = 2'b11
  } bp_mode_e;

  localparam logic [1:0] CTR_INIT = 2'b01;

  // Saturating 2-bit counter step
  function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic up);
    logic [1:0] nxt;
    if (up) nxt = (cur == 2'b11) ? cur : cur + 2'b01;
    else    nxt = (cur == 2'b00) ? cur : cur - 2'b01;
    return nxt;
  endfunction

endpackage

// File: rtl/bp_counter_table.sv
module bp_counter_table #(
  parameter int ENTRIES = 16,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_taken,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);
  import bp_pkg::*;

  logic [1:0] ctr_q [ENTRIES];
  logic [1:0] wr_cur;
  logic [1:0] wr_nxt;

  always_comb begin
    wr_cur = ctr_q[wr_idx];
    wr_nxt = ctr_step(wr_cur, wr_taken);
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic ent_en;
    assign ent_en = wr_en && (wr_idx == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctr_q[i] <= CTR_INIT;
      else if (ent_en) ctr_q[i] <= wr_nxt;
    end
  end

  assign rd_taken = ctr_q[rd_idx][1];

  // Checker state: remembers the last write to compare the stored result
  logic             chk_en;
  logic             chk_up;
  logic [1:0]       chk_prev;
  logic [IDX_W-1:0] chk_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_en   <= 1'b0;
      chk_up   <= 1'b0;
      chk_prev <= 2'b00;
      chk_idx  <= '0;
    end else begin
      chk_en   <= wr_en;
      chk_up   <= wr_taken;
      chk_prev <= wr_cur;
      chk_idx  <= wr_idx;
    end
  end

  p_sat_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && chk_up && chk_prev == 2'b11) |-> (ctr_q[chk_idx] == 2'b11));
  p_sat_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && !chk_up && chk_prev == 2'b00) |-> (ctr_q[chk_idx] == 2'b00));
  p_count_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && chk_up && chk_prev != 2'b11) |-> (ctr_q[chk_idx] == chk_prev + 2'b01));
  p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && !chk_up && chk_prev != 2'b00) |-> (ctr_q[chk_idx] == chk_prev - 2'b01));

endmodule

// File: rtl/bp_history_table.sv
module bp_history_table #(
  parameter int ENTRIES = 8,
  parameter int HIST_W  = 4,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [HIST_W-1:0] rd_hist,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_bit,
  output logic [HIST_W-1:0] wr_hist_cur
);

  logic [HIST_W-1:0] hist_q [ENTRIES];
  logic [HIST_W-1:0] hist_nxt;

  assign wr_hist_cur = hist_q[wr_idx];

  if (HIST_W > 1) begin : g_shift
    assign hist_nxt = {wr_hist_cur[HIST_W-2:0], wr_bit};
  end else begin : g_single
    assign hist_nxt = wr_bit;
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic ent_en;
    assign ent_en = wr_en && (wr_idx == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      hist_q[i] <= '0;
      else if (ent_en) hist_q[i] <= hist_nxt;
    end
  end

  assign rd_hist = hist_q[rd_idx];

  logic              chk_en;
  logic              chk_bit;
  logic [HIST_W-1:0] chk_prev;
  logic [IDX_W-1:0]  chk_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_en   <= 1'b0;
      chk_bit  <= 1'b0;
      chk_prev <= '0;
      chk_idx  <= '0;
    end else begin
      chk_en   <= wr_en;
      chk_bit  <= wr_bit;
      chk_prev <= wr_hist_cur;
      chk_idx  <= wr_idx;
    end
  end

  if (HIST_W > 1) begin : g_chk_shift
    p_hist_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
      chk_en |-> (hist_q[chk_idx] == {chk_prev[HIST_W-2:0], chk_bit}));
  end else begin : g_chk_single
    p_hist_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
      chk_en |-> (hist_q[chk_idx][0] == chk_bit));
  end

endmodule

// File: rtl/branch_dir_predictor.sv
module branch_dir_predictor #(
  parameter int ADDR_W      = 32,
  parameter int WORD_OFS    = 2,
  parameter int BIM_ENTRIES = 16,
  parameter int L1_ENTRIES  = 8,
  parameter int L2_ENTRIES  = 64,
  parameter int HIST_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_sel,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_taken,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic              upd_taken
);
  import bp_pkg::*;

  localparam int BIM_IDX_W = (BIM_ENTRIES > 1) ? $clog2(BIM_ENTRIES) : 1;
  localparam int L1_IDX_W  = (L1_ENTRIES > 1) ? $clog2(L1_ENTRIES) : 1;
  localparam int L2_IDX_W  = (L2_ENTRIES > 1) ? $clog2(L2_ENTRIES) : 1;
  localparam int L2_ADDR_W = (L2_IDX_W > HIST_W) ? (L2_IDX_W - HIST_W) : 0;

  bp_mode_e mode;
  assign mode = bp_mode_e'(mode_sel);

  // Table write enables: only the active mode trains
  logic bim_wr_en;
  logic two_wr_en;
  assign bim_wr_en = upd_valid && (mode == BP_BIMODAL);
  assign two_wr_en = upd_valid && (mode == BP_TWO_LEVEL);

  // Bimodal path
  logic [BIM_IDX_W-1:0] bim_rd_idx;
  logic [BIM_IDX_W-1:0] bim_wr_idx;
  logic                 bim_pred;
  assign bim_rd_idx = lk_addr[WORD_OFS +: BIM_IDX_W];
  assign bim_wr_idx = upd_addr[WORD_OFS +: BIM_IDX_W];

  bp_counter_table #(.ENTRIES(BIM_ENTRIES)) u_bim_tbl (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (bim_rd_idx),
    .rd_taken (bim_pred),
    .wr_en    (bim_wr_en),
    .wr_idx   (bim_wr_idx),
    .wr_taken (upd_taken)
  );

  // Two-level path: first level history registers
  logic [L1_IDX_W-1:0] l1_rd_idx;
  logic [L1_IDX_W-1:0] l1_wr_idx;
  logic [HIST_W-1:0]   lk_hist;
  logic [HIST_W-1:0]   up_hist;
  assign l1_rd_idx = lk_addr[WORD_OFS +: L1_IDX_W];
  assign l1_wr_idx = upd_addr[WORD_OFS +: L1_IDX_W];

  bp_history_table #(.ENTRIES(L1_ENTRIES), .HIST_W(HIST_W)) u_hist_tbl (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_idx      (l1_rd_idx),
    .rd_hist     (lk_hist),
    .wr_en       (two_wr_en),
    .wr_idx      (l1_wr_idx),
    .wr_bit      (upd_taken),
    .wr_hist_cur (up_hist)
  );

  // Second level index: history on top, low address bits below
  logic [L2_IDX_W-1:0] l2_rd_idx;
  logic [L2_IDX_W-1:0] l2_wr_idx;
  logic                two_pred;

  if (L2_ADDR_W > 0) begin : g_l2_mix
    assign l2_rd_idx = {lk_hist, lk_addr[WORD_OFS +: L2_ADDR_W]};
    assign l2_wr_idx = {up_hist, upd_addr[WORD_OFS +: L2_ADDR_W]};
  end else begin : g_l2_hist
    assign l2_rd_idx = lk_hist[L2_IDX_W-1:0];
    assign l2_wr_idx = up_hist[L2_IDX_W-1:0];
  end

  bp_counter_table #(.ENTRIES(L2_ENTRIES)) u_pat_tbl (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (l2_rd_idx),
    .rd_taken (two_pred),
    .wr_en    (two_wr_en),
    .wr_idx   (l2_wr_idx),
    .wr_taken (upd_taken)
  );

  // Output select
  always_comb begin
    unique case (mode)
      BP_STATIC_NT: lk_taken = 1'b0;
      BP_STATIC_T:  lk_taken = 1'b1;
      BP_BIMODAL:   lk_taken = bim_pred;
      default:      lk_taken = two_pred;
    endcase
  end

  logic unused_addr_bits;
  assign unused_addr_bits = ^{lk_addr, upd_addr};

  p_static_nt_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b00) |-> !lk_taken);
  p_static_t_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b01) |-> lk_taken);
  p_static_no_train_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel[1] == 1'b0) |-> !(bim_wr_en || two_wr_en));

endmodule

// File: tb/branch_dir_predictor_tb.sv
module branch_dir_predictor_tb;

  logic        clk;
  logic        rst_n;
  logic [1:0]  mode_sel;
  logic [31:0] lk_addr;
  logic        lk_taken;
  logic        upd_valid;
  logic [31:0] upd_addr;
  logic        upd_taken;

  int n_checks = 0;
  int n_fails  = 0;

  branch_dir_predictor u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_sel  (mode_sel),
    .lk_addr   (lk_addr),
    .lk_taken  (lk_taken),
    .upd_valid (upd_valid),
    .upd_addr  (upd_addr),
    .upd_taken (upd_taken)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // mode, address, update, outcome, expected prediction before the update
  typedef struct packed {
    logic [1:0]  mode;
    logic [15:0] addr;
    logic        upd;
    logic        tkn;
    logic        exp;
  } vec_t;

  localparam int NVEC = 21;
  localparam vec_t VECS [NVEC] = '{
    '{2'd2, 16'h0010, 1'b1, 1'b1, 1'b0},  // R3 R5 weak NT, R9 old value
    '{2'd2, 16'h0010, 1'b1, 1'b1, 1'b1},  // R4 up
    '{2'd2, 16'h0010, 1'b1, 1'b1, 1'b1},  // R4 to 3
    '{2'd2, 16'h0010, 1'b1, 1'b0, 1'b1},  // R4 held at 3
    '{2'd2, 16'h0010, 1'b1, 1'b0, 1'b1},  // R4 down to 1
    '{2'd2, 16'h0010, 1'b1, 1'b0, 1'b0},  // R4 to 0
    '{2'd2, 16'h0010, 1'b1, 1'b0, 1'b0},  // R4 held at 0
    '{2'd2, 16'h0010, 1'b1, 1'b1, 1'b0},  // R4 up to 1
    '{2'd2, 16'h0010, 1'b0, 1'b0, 1'b0},  // R4 value 1
    '{2'd2, 16'h0050, 1'b1, 1'b1, 1'b0},  // R10 alias trains shared entry
    '{2'd2, 16'h0010, 1'b0, 1'b0, 1'b1},  // R10 alias visible
    '{2'd2, 16'h0014, 1'b0, 1'b0, 1'b0},  // R3 neighbour untouched
    '{2'd0, 16'h0010, 1'b1, 1'b1, 1'b0},  // R1 update ignored
    '{2'd1, 16'h0014, 1'b1, 1'b1, 1'b1},  // R2 update ignored
    '{2'd0, 16'h0014, 1'b1, 1'b1, 1'b0},  // R1 update ignored
    '{2'd2, 16'h0014, 1'b1, 1'b1, 1'b0},  // R8 still 01
    '{2'd2, 16'h0014, 1'b0, 1'b0, 1'b1},  // R8 now 10
    '{2'd2, 16'h0010, 1'b1, 1'b0, 1'b1},  // R8 entry still 2
    '{2'd2, 16'h0010, 1'b0, 1'b0, 1'b0},  // R8 now 1
    '{2'd3, 16'h0014, 1'b1, 1'b0, 1'b0},  // R7 two-level fresh counter
    '{2'd2, 16'h0014, 1'b0, 1'b0, 1'b1}   // R8 bimodal untouched by two-level
  };

  task automatic check(input string req, input logic got, input logic exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: lk_taken=%b expected %b (t=%0t)", req, got, exp, $time);
    end
  endtask

  // Drive after a falling edge, look at the output one ns later
  task automatic drive(input logic [1:0] m, input logic [31:0] a,
                       input logic u, input logic t);
    @(negedge clk);
    mode_sel  = m;
    lk_addr   = a;
    upd_addr  = a;
    upd_valid = u;
    upd_taken = t;
    #1;
  endtask

  task automatic idle_edge;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; mode_sel = 2'd2; lk_addr = '0; upd_addr = '0;
    upd_valid = 1'b0; upd_taken = 1'b0;
    #1;
    check("R5 reset bimodal", lk_taken, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    drive(2'd3, 32'h0000_0000, 1'b0, 1'b0);
    check("R5 reset two-level", lk_taken, 1'b0);
    drive(2'd1, 32'h0000_0abc, 1'b0, 1'b0);
    check("R2 static taken", lk_taken, 1'b1);

    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i].mode, {16'h0, VECS[i].addr}, VECS[i].upd, VECS[i].tkn);
      check($sformatf("R3/R4/R8/R9/R10 vector %0d", i), lk_taken, VECS[i].exp);
    end
    idle_edge();

    // R5: reset mid-run clears trained state (entry 0x14 was at 10)
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    drive(2'd2, 32'h0000_0014, 1'b0, 1'b0);
    check("R5 retrained entry cleared", lk_taken, 1'b0);

    // Two-level training on address 0
    drive(2'd3, 32'h0000_0000, 1'b1, 1'b1);  // ctr[0]=2, hist=0001
    drive(2'd3, 32'h0000_0000, 1'b0, 1'b0);
    check("R7 history selects new counter", lk_taken, 1'b0);
    drive(2'd3, 32'h0000_0000, 1'b1, 1'b1);  // ctr[4]=2, hist=0011
    drive(2'd3, 32'h0000_0000, 1'b1, 1'b1);  // ctr[12]=2, hist=0111
    drive(2'd3, 32'h0000_0000, 1'b1, 1'b1);  // ctr[28]=2, hist=1111
    drive(2'd3, 32'h0000_0000, 1'b1, 1'b1);  // ctr[60]=2, hist=1111
    drive(2'd3, 32'h0000_0000, 1'b0, 1'b0);
    check("R6 all-ones history predicts taken", lk_taken, 1'b1);
    drive(2'd3, 32'h0000_0020, 1'b0, 1'b0);
    check("R6 shared history slot", lk_taken, 1'b1);
    drive(2'd3, 32'h0000_0004, 1'b0, 1'b0);
    check("R6 separate history slot", lk_taken, 1'b0);
    drive(2'd3, 32'h0000_0000, 1'b1, 1'b0);  // ctr[60]=1, hist=1110
    drive(2'd3, 32'h0000_0000, 1'b0, 1'b0);
    check("R6 shifted-in not-taken", lk_taken, 1'b0);
    drive(2'd2, 32'h0000_0000, 1'b0, 1'b0);
    check("R8 bimodal untouched by two-level", lk_taken, 1'b0);
    drive(2'd0, 32'h0000_0000, 1'b0, 1'b0);
    check("R1 static not-taken", lk_taken, 1'b0);
    idle_edge();

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule